// File: doc/BRIEF.md
# Latched Programmable Binary Delay Line

This block delays a one-bit sample stream by a programmable whole number of clock periods. The stream passes through ten binary-weighted delay sections, and each section is either inserted into the path or bypassed. A ten-bit code selects the sections. The code is held in a select latch with a load/hold strobe. While the strobe is low the latch follows the select pins. When the strobe rises, the latch freezes the code.

Two force inputs override the code. One parks the line at its shortest path. The other sets the longest path, which is one unit beyond the all-ones code. An output-off input drives the output low. An eleventh select bit goes through the same latch and drives a complementary cascade pair. With that pair, a second instance can be parked at its minimum or pushed to its maximum, which extends the range of a chain.

The stream takes one sample on every clock and produces one sample on every clock. There is no valid/ready handshake and no back-pressure: a sample is accepted on every rising edge. After any change of the effective code, the samples already in the line may be dropped or repeated.

Top module: `prog_delay_line`

## Requirements
- R1: With the code held steady, `dout` equals `din` delayed by 2 + N clock cycles. N is the sum of 2^k over every set bit k of `sel[9:0]`, so bit 0 weighs 1 and bit 9 weighs 512. The all-ones code gives N = 1023.
- R2: While `load_hold` is low, a change on `sel` takes effect at once and sets the delay of the samples that follow.
- R3: On the clock where `load_hold` is first seen high, the select bits present in that clock are captured. Later changes on `sel` have no effect on the delay or on the cascade pair until `load_hold` returns low.
- R4: When `force_min` is high, the programmed delay is 0 (total latency 2 cycles) whatever the code. This also holds when `force_max` is high at the same time.
- R5: When `force_max` is high and `force_min` is low, the programmed delay is 1024 cycles (total latency 1026).
- R6: In each cycle after a clock edge that sampled `out_off` high, `dout` is 0 whatever the input.
- R7: `cas_hi` follows the latched `sel[10]` one cycle later, and `cas_lo` is always its complement.
- R8: At code 0 with no force input high, the latency is exactly 2 cycles: one input register and one output register.
- R9: Synchronous active-high `rst` clears every delay register and the select latch. After reset, `dout` is 0, `cas_hi` is 0 and `cas_lo` is 1.
- R10: Chain two instances. The first instance's `cas_lo` drives the second's `force_min`, and its `cas_hi` drives the second's `force_max`. With `sel[10]` low, the total latency is (2 + N) + 2. With `sel[10]` high, it is (2 + N) + 1026.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Input sample stream, one sample per clock |
| sel | input | 11 | Bits 9..0 are the binary delay code; bit 10 is the cascade control |
| load_hold | input | 1 | Low: latch transparent; rising: capture; high: hold |
| force_min | input | 1 | Force the shortest delay (highest priority) |
| force_max | input | 1 | Force the longest delay (1024 units) |
| out_off | input | 1 | High holds `dout` low |
| dout | output | 1 | Delayed sample stream |
| cas_hi | output | 1 | True cascade output, equal to the latched bit 10 |
| cas_lo | output | 1 | Complement cascade output |

## Verification
Random bit streams are sent through every single-bit code and the all-ones code. A weight on the wrong section, or two weights swapped, shows up as a wrong shift against an ideal reference. The force inputs are tried alone and together, over codes chosen so that a reversed priority or a missing extra unit moves the latency. One sequence freezes the code and then changes the pins, which separates hold from transparency. Output-off runs, cascade toggles and a two-instance chain cover gating and range extension.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  localparam int unsigned PDL_STAGES_DEF = 10;

  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_MIN  = 2'd1,
    OVR_MAX  = 2'd2
  } ovr_mode_t;
endpackage

// File: rtl/pdl_code_latch.sv
module pdl_code_latch #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_hold,
  input  logic [W-1:0] sel_in,
  output logic [W-1:0] code_out
);
  logic [W-1:0] hold_q;
  logic         strobe_q;
  logic         frozen;

  // Frozen only once the strobe has been high for a full cycle; in the
  // rising cycle the pins still pass through and are captured at its edge.
  assign frozen   = load_hold && strobe_q;
  assign code_out = frozen ? hold_q : sel_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= load_hold;
      if (!frozen) hold_q <= sel_in;
    end
  end

  // R3: with the strobe held high the effective code does not move
  a_r3_code_frozen: assert property (@(posedge clk) disable iff (rst)
    (load_hold && $past(load_hold) && !$past(rst)) |-> $stable(code_out));
endmodule

// File: rtl/pdl_code_resolve.sv
module pdl_code_resolve
  import pdl_pkg::*;
#(
  parameter int unsigned STAGES = 10
) (
  input  logic [STAGES-1:0] code,
  input  logic              force_min,
  input  logic              force_max,
  output logic [STAGES-1:0] insert,
  output logic              insert_extra
);
  ovr_mode_t mode;

  always_comb begin
    if (force_min)      mode = OVR_MIN;
    else if (force_max) mode = OVR_MAX;
    else                mode = OVR_NONE;
  end

  always_comb begin
    case (mode)
      OVR_MIN: begin
        insert       = '0;
        insert_extra = 1'b0;
      end
      OVR_MAX: begin
        insert       = '1;
        insert_extra = 1'b1;
      end
      default: begin
        insert       = code;
        insert_extra = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pdl_stage.sv
module pdl_stage #(
  parameter int unsigned DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic insert,
  output logic dout
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= (sr_q << 1) | DEPTH'(din);
  end

  assign dout = insert ? sr_q[DEPTH-1] : din;
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
  import pdl_pkg::*;
#(
  parameter int unsigned STAGES = PDL_STAGES_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  input  logic [STAGES:0] sel,
  input  logic            load_hold,
  input  logic            force_min,
  input  logic            force_max,
  input  logic            out_off,
  output logic            dout,
  output logic            cas_hi,
  output logic            cas_lo
);
  localparam int unsigned SEL_W = STAGES + 1;
  localparam int unsigned TAPS  = STAGES + 2;

  logic [SEL_W-1:0]  code;
  logic [STAGES-1:0] ins_bits;
  logic              ins_extra;
  logic [TAPS-1:0]   chain;
  logic              in_q;
  logic              out_q;
  logic              cas_q;

  pdl_code_latch #(.W(SEL_W)) u_latch (
    .clk(clk), .rst(rst), .load_hold(load_hold),
    .sel_in(sel), .code_out(code)
  );

  pdl_code_resolve #(.STAGES(STAGES)) u_resolve (
    .code(code[STAGES-1:0]), .force_min(force_min), .force_max(force_max),
    .insert(ins_bits), .insert_extra(ins_extra)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= 1'b0;
      out_q <= 1'b0;
      cas_q <= 1'b0;
    end else begin
      in_q  <= din;
      out_q <= out_off ? 1'b0 : chain[TAPS-1];
      cas_q <= code[STAGES];
    end
  end

  assign chain[0] = in_q;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    pdl_stage #(.DEPTH(1 << k)) u_stage (
      .clk(clk), .rst(rst), .din(chain[k]),
      .insert(ins_bits[k]), .dout(chain[k+1])
    );
  end

  // single extra unit, used only by the maximum override
  pdl_stage #(.DEPTH(1)) u_extra (
    .clk(clk), .rst(rst), .din(chain[STAGES]),
    .insert(ins_extra), .dout(chain[STAGES+1])
  );

  assign dout   = out_q;
  assign cas_hi = cas_q;
  assign cas_lo = ~cas_q;

  // R4: minimum override removes every section, priority over maximum
  a_r4_min_wins: assert property (@(posedge clk) disable iff (rst)
    force_min |-> (ins_bits == '0 && !ins_extra));
  // R5: maximum override inserts all sections plus the extra unit
  a_r5_max_all: assert property (@(posedge clk) disable iff (rst)
    (force_max && !force_min) |-> (&ins_bits && ins_extra));
  // R6: output held low after out_off was sampled
  a_r6_off_low: assert property (@(posedge clk) disable iff (rst)
    $past(out_off) |-> !dout);
  // R7: cascade pair always complementary
  a_r7_cas_pair: assert property (@(posedge clk) disable iff (rst)
    cas_hi != cas_lo);
  // R7: with the latch open, cascade follows the pin a cycle later
  a_r7_cas_follow: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_hold) && !$past(rst)) |-> (cas_hi == $past(sel[STAGES])));
  // R9: state right after reset
  a_r9_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dout && !cas_hi && cas_lo));
endmodule

// File: tb/sim_prog_delay_line.sv
module sim_prog_delay_line;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    due;
    bit    val;
    bit    which;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        din = 1'b0;
  logic [10:0] sel = '0;
  logic        load_hold = 1'b0;
  logic        force_min = 1'b0;
  logic        force_max = 1'b0;
  logic        out_off = 1'b0;
  logic        dout0, cas_hi0, cas_lo0;
  logic        dout1, cas_hi1, cas_lo1;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_err = 0;
  exp_t sb_q[$];
  exp_t it;
  bit   got;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prog_delay_line u0 (
    .clk(clk), .rst(rst), .din(din), .sel(sel), .load_hold(load_hold),
    .force_min(force_min), .force_max(force_max), .out_off(out_off),
    .dout(dout0), .cas_hi(cas_hi0), .cas_lo(cas_lo0)
  );

  // second instance chained off the first one's cascade pair (R10)
  prog_delay_line u1 (
    .clk(clk), .rst(rst), .din(dout0), .sel(11'd0), .load_hold(1'b0),
    .force_min(cas_lo0), .force_max(cas_hi0), .out_off(1'b0),
    .dout(dout1), .cas_hi(cas_hi1), .cas_lo(cas_lo1)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pop items whose due cycle has come and compare
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      it  = sb_q.pop_front();
      got = it.which ? dout1 : dout0;
      chk(got === it.val && it.due == cyc, it.tag, int'(got), int'(it.val));
    end
  end

  task automatic cfg(logic [10:0] s, bit lh, bit fmin, bit fmax, bit off);
    @(negedge clk);
    sel = s; load_hold = lh; force_min = fmin; force_max = fmax; out_off = off;
  endtask

  // driver: random samples with expected values pushed to the scoreboard
  task automatic drive(int n, int lat, bit which, string tag, bit zero);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      @(negedge clk);
      din     = 1'($urandom_range(0, 1));
      e.due   = cyc + lat;
      e.val   = zero ? 1'b0 : din;
      e.which = which;
      e.tag   = tag;
      sb_q.push_back(e);
    end
    while (sb_q.size() > 0) begin
      @(negedge clk);
      din = 1'($urandom_range(0, 1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=0 pending items", sb_q.size());
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    din = 1'b1;
    sel = 11'h7FF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(dout0 == 1'b0, "R9 dout", int'(dout0), 0);
    chk(cas_hi0 == 1'b0, "R9 cas_hi", int'(cas_hi0), 0);
    chk(cas_lo0 == 1'b1, "R9 cas_lo", int'(cas_lo0), 1);
    sel = '0;
    rst = 1'b0;
    @(negedge clk);
    chk(dout0 == 1'b0, "R9 dout after release", int'(dout0), 0);

    // R8: code 0 gives the fixed two-cycle latency
    cfg(11'd0, 0, 0, 0, 0);
    drive(40, 2, 0, "R8", 0);

    // R1: every single-bit code
    for (int k = 0; k < 10; k++) begin
      cfg(11'(1 << k), 0, 0, 0, 0);
      drive(24, 2 + (1 << k), 0, "R1", 0);
    end
    cfg(11'h3FF, 0, 0, 0, 0);
    drive(24, 2 + 1023, 0, "R1", 0);
    cfg(11'd341, 0, 0, 0, 0);
    drive(24, 2 + 341, 0, "R1", 0);

    // R5: maximum override, one unit beyond all-ones
    cfg(11'd5, 0, 0, 1, 0);
    drive(24, 2 + 1024, 0, "R5", 0);
    // R4: minimum override, alone and together with maximum
    cfg(11'h3FF, 0, 1, 0, 0);
    drive(24, 2, 0, "R4", 0);
    cfg(11'h3FF, 0, 1, 1, 0);
    drive(24, 2, 0, "R4", 0);

    // R3: capture on the rising strobe, then pins ignored
    cfg(11'd37, 0, 0, 0, 0);
    cfg(11'd37, 1, 0, 0, 0);
    cfg(11'd900, 1, 0, 0, 0);
    drive(32, 2 + 37, 0, "R3", 0);
    // R2: reopening the latch makes the pins take effect at once
    cfg(11'd900, 0, 0, 0, 0);
    drive(24, 2 + 900, 0, "R2", 0);
    cfg(11'd12, 0, 0, 0, 0);
    drive(24, 2 + 12, 0, "R2", 0);

    // R6: output off forces zeros, then release
    cfg(11'd3, 0, 0, 0, 1);
    drive(32, 5, 0, "R6", 1);
    cfg(11'd3, 0, 0, 0, 0);
    drive(32, 5, 0, "R6", 0);

    // R7: cascade follow, hold and release
    cfg(11'h400, 0, 0, 0, 0);
    @(negedge clk);
    chk(cas_hi0 == 1'b1, "R7 cas_hi set", int'(cas_hi0), 1);
    chk(cas_lo0 == 1'b0, "R7 cas_lo set", int'(cas_lo0), 0);
    cfg(11'h400, 1, 0, 0, 0);
    cfg(11'h000, 1, 0, 0, 0);
    @(negedge clk);
    chk(cas_hi0 == 1'b1, "R7 cas held", int'(cas_hi0), 1);
    cfg(11'h000, 0, 0, 0, 0);
    @(negedge clk);
    chk(cas_hi0 == 1'b0, "R7 cas_hi clear", int'(cas_hi0), 0);
    chk(cas_lo0 == 1'b1, "R7 cas_lo clear", int'(cas_lo0), 1);

    // R10: two-instance chain, second parked at minimum then maximum
    cfg(11'd20, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    drive(24, (2 + 20) + 2, 1, "R10", 0);
    cfg(11'h400 | 11'd20, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    drive(24, (2 + 20) + 1026, 1, "R10", 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule